// File: doc/BRIEF.md
# Memory low-power mode sequencer

This block lives inside a DDR-style memory controller and decides when the memory goes into a low-power state, which state it takes, and how the clock enable, the memory clock and the controller clock are switched on the way in and on the way out. It offers five modes. Two are power-down modes: a plain one, and one that also stops the memory clock when a mobile device is configured. Three are self-refresh modes: a plain one, one that also stops the memory clock, and one that stops both the memory clock and the controller clock while a DLL keep-alive stays asserted.

Each mode has an enable bit and an automatic/manual select bit. Automatic modes are entered when one of four idle counters reaches its programmed threshold. Manual modes are entered at the end of a burst. Any pending request ends a low-power state. Loss of idle ends a state that was entered automatically, and clearing the enable bit of the active mode ends it too. The exit sequence ends with a programmable wait before the block reports ready.

Mode bit positions, used by `mode_en` and `mode_auto`: bit 0 power-down, bit 1 power-down with clock gating, bit 2 self-refresh, bit 3 self-refresh with memory clock gating, bit 4 self-refresh with full clock gating. `cur_mode` encoding: 0 none, 1 to 5 the modes in that same order.

Top module: `lp_seq`

## Requirements
- R1: After synchronous reset, cke, mem_clk_en, ctl_clk_en and ready are 1, dll_keep and ref_inhibit are 0, and cur_mode is 0.
- R2: Each idle counter counts cycles in which idle is 1 and req_pending is 0 while the block is ready. Any cycle with idle low or a pending request clears all counters. With only counter k eligible and threshold T, cke falls T+1 cycles after idle rises.
- R3: Automatic entry needs the mode's enable bit, its auto bit and its counter expired, all at once. A threshold of 0 disables that counter. An enabled mode with its auto bit at 0 never enters through a counter.
- R4: Counter 0 (idle_thr bits [CNT_W-1:0]) selects the gated power-down mode when bit 1 is enabled and automatic, and plain power-down otherwise. Counters 1, 2 and 3 select modes 3, 4 and 5. The counter that expires first decides the mode; on a tie the deepest mode (highest cur_mode) wins.
- R5: A manual mode (enable 1, auto 0) is entered only in the cycle after burst_done is seen high with req_pending low. cke falls one cycle after that burst_done.
- R6: In mode 2 the memory clock is gated only when mobile is 1. With mobile at 0 all outputs behave as in mode 1. In modes 1 and 2 ref_inhibit stays 0.
- R7: In the self-refresh modes (3 to 5) ref_inhibit is 1 exactly while cke is 0. In mode 3 both clocks keep running.
- R8: In mode 5 both clock enables go to 0 and dll_keep is 1 while the controller clock is gated. In mode 4 only the memory clock is gated.
- R9: Entry drops cke first, then the memory clock one cycle later, then the controller clock one cycle after that. Steps a mode does not use are skipped.
- R10: A low-power state ends on req_pending, on idle low (automatic entry only), or when the active mode's enable bit is cleared. An exit that starts during entry waits until entry has finished.
- R11: Exit restores the controller clock, then the memory clock, then cke, one step per cycle starting the cycle after the exit trigger. ready rises, and cur_mode returns to 0, exit_wait+1 cycles after cke rises.
- R12: cur_mode shows the active mode from the cycle cke falls until ready rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 5 | Per-mode enable |
| mode_auto | input | 5 | Per-mode automatic (1) / manual (0) select |
| mobile | input | 1 | Mobile memory device configured |
| idle | input | 1 | Controller has no work |
| burst_done | input | 1 | Current burst completes this cycle |
| req_pending | input | 1 | A new access is waiting |
| idle_thr | input | 4*CNT_W | Four idle thresholds, counter k at bits k*CNT_W |
| exit_wait | input | EXIT_W | Extra cycles after cke rises before ready |
| cke | output | 1 | Memory clock enable pin level |
| mem_clk_en | output | 1 | Memory clock gate enable |
| ctl_clk_en | output | 1 | Controller clock gate enable |
| dll_keep | output | 1 | DLL keep-alive while controller clock is gated |
| ref_inhibit | output | 1 | Suppress explicit refresh commands |
| cur_mode | output | 3 | Active low-power mode |
| ready | output | 1 | Block is in normal operation |

## Verification
The hardest cases to reach are the races between counters: two counters that expire in the same cycle, one that is disabled by a zero threshold, and a counter that must restart after idle drops for a single cycle. The vector table sets the thresholds so that each race is decided by counting alone, and then measures the exact cycle at which cke falls. Manual entry uses single-cycle burst_done pulses. Exits are started through each of the three triggers, and the bench records the cycle in which each clock enable, cke and ready comes back.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int NUM_MODES = 5;
  localparam int NUM_CNT   = 4;

  typedef enum logic [2:0] {
    LPM_NONE = 3'd0,
    LPM_PD   = 3'd1,
    LPM_PDG  = 3'd2,
    LPM_SR   = 3'd3,
    LPM_SRG  = 3'd4,
    LPM_SRFG = 3'd5
  } lpm_t;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_GMEM,
    ST_GCTL,
    ST_LOW,
    ST_RMEM,
    ST_RCKE,
    ST_WAIT
  } st_t;

  function automatic logic mode_gates_mem(lpm_t m, logic mob);
    return (m == LPM_PDG && mob) || m == LPM_SRG || m == LPM_SRFG;
  endfunction

  function automatic logic mode_gates_ctl(lpm_t m);
    return m == LPM_SRFG;
  endfunction

  function automatic logic mode_is_sr(lpm_t m);
    return m == LPM_SR || m == LPM_SRG || m == LPM_SRFG;
  endfunction
endpackage

// File: rtl/lp_idle_timers.sv
module lp_idle_timers
  import lp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic [NUM_CNT*CNT_W-1:0] thr,
  output logic [NUM_CNT-1:0]       expired
);
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    assign lim = thr[k*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
      if (rst || !run) begin
        cnt <= '0;
      end else if (cnt < lim) begin
        cnt <= cnt + 1'b1;
      end
    end

    assign expired[k] = (lim != '0) && (cnt >= lim);
  end
endmodule

// File: rtl/lp_mode_pick.sv
module lp_mode_pick
  import lp_pkg::*;
(
  input  logic [NUM_MODES-1:0] en,
  input  logic [NUM_MODES-1:0] auto_sel,
  input  logic [NUM_CNT-1:0]   expired,
  input  logic                 idle,
  input  logic                 req,
  input  logic                 burst_done,
  output logic                 go,
  output lpm_t                 pick,
  output logic                 pick_auto
);
  logic [NUM_MODES-1:0] auto_ok;
  logic [NUM_MODES-1:0] auto_hit;
  logic [NUM_MODES-1:0] man_hit;
  logic [NUM_MODES-1:0] hit;
  logic                 quiet;

  assign auto_ok = en & auto_sel;
  assign quiet   = idle && !req;

  always_comb begin
    auto_hit    = '0;
    auto_hit[0] = expired[0] && auto_ok[0] && !auto_ok[1] && quiet;
    auto_hit[1] = expired[0] && auto_ok[1] && quiet;
    for (int i = 2; i < NUM_MODES; i++) begin
      auto_hit[i] = expired[i-1] && auto_ok[i] && quiet;
    end
  end

  assign man_hit = en & ~auto_sel & {NUM_MODES{burst_done && !req}};
  assign hit     = auto_hit | man_hit;
  assign go      = |hit;

  always_comb begin
    pick      = LPM_NONE;
    pick_auto = 1'b0;
    for (int i = 0; i < NUM_MODES; i++) begin
      if (hit[i]) begin
        pick      = lpm_t'(3'(i + 1));
        pick_auto = auto_hit[i];
      end
    end
  end
endmodule

// File: rtl/lp_step_fsm.sv
module lp_step_fsm
  import lp_pkg::*;
#(
  parameter int EXIT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  lpm_t                 pick,
  input  logic                 pick_auto,
  input  logic                 mobile,
  input  logic                 idle,
  input  logic                 req,
  input  logic [NUM_MODES-1:0] en,
  input  logic [EXIT_W-1:0]    exit_wait,
  output logic                 cke,
  output logic                 mem_clk_en,
  output logic                 ctl_clk_en,
  output logic                 dll_keep,
  output logic                 ref_inhibit,
  output lpm_t                 cur_mode,
  output logic                 ready
);
  st_t              st;
  logic             auto_q;
  logic             gmem_q;
  logic             gctl_q;
  logic [EXIT_W-1:0] wcnt;
  logic             en_cur;
  logic             leave;

  always_comb begin
    en_cur = 1'b0;
    for (int i = 0; i < NUM_MODES; i++) begin
      if (cur_mode == lpm_t'(3'(i + 1))) en_cur = en[i];
    end
  end

  assign leave = req || !en_cur || (auto_q && !idle);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_RUN;
      cke         <= 1'b1;
      mem_clk_en  <= 1'b1;
      ctl_clk_en  <= 1'b1;
      dll_keep    <= 1'b0;
      ref_inhibit <= 1'b0;
      cur_mode    <= LPM_NONE;
      ready       <= 1'b1;
      auto_q      <= 1'b0;
      gmem_q      <= 1'b0;
      gctl_q      <= 1'b0;
      wcnt        <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (go) begin
            cke         <= 1'b0;
            ready       <= 1'b0;
            cur_mode    <= pick;
            auto_q      <= pick_auto;
            ref_inhibit <= mode_is_sr(pick);
            gmem_q      <= mode_gates_mem(pick, mobile);
            gctl_q      <= mode_gates_ctl(pick);
            st          <= mode_gates_mem(pick, mobile) ? ST_GMEM : ST_LOW;
          end
        end
        ST_GMEM: begin
          mem_clk_en <= 1'b0;
          st         <= gctl_q ? ST_GCTL : ST_LOW;
        end
        ST_GCTL: begin
          ctl_clk_en <= 1'b0;
          dll_keep   <= 1'b1;
          st         <= ST_LOW;
        end
        ST_LOW: begin
          if (leave) begin
            if (gctl_q) begin
              ctl_clk_en <= 1'b1;
              dll_keep   <= 1'b0;
              st         <= ST_RMEM;
            end else if (gmem_q) begin
              mem_clk_en <= 1'b1;
              st         <= ST_RCKE;
            end else begin
              cke         <= 1'b1;
              ref_inhibit <= 1'b0;
              wcnt        <= '0;
              st          <= ST_WAIT;
            end
          end
        end
        ST_RMEM: begin
          mem_clk_en <= 1'b1;
          st         <= ST_RCKE;
        end
        ST_RCKE: begin
          cke         <= 1'b1;
          ref_inhibit <= 1'b0;
          wcnt        <= '0;
          st          <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wcnt == exit_wait) begin
            ready    <= 1'b1;
            cur_mode <= LPM_NONE;
            auto_q   <= 1'b0;
            st       <= ST_RUN;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/lp_seq.sv
module lp_seq
  import lp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int EXIT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_MODES-1:0]     mode_en,
  input  logic [NUM_MODES-1:0]     mode_auto,
  input  logic                     mobile,
  input  logic                     idle,
  input  logic                     burst_done,
  input  logic                     req_pending,
  input  logic [NUM_CNT*CNT_W-1:0] idle_thr,
  input  logic [EXIT_W-1:0]        exit_wait,
  output logic                     cke,
  output logic                     mem_clk_en,
  output logic                     ctl_clk_en,
  output logic                     dll_keep,
  output logic                     ref_inhibit,
  output logic [2:0]               cur_mode,
  output logic                     ready
);
  logic               run;
  logic [NUM_CNT-1:0] expired;
  logic               go;
  lpm_t               pick;
  logic               pick_auto;
  lpm_t               mode_q;

  assign run      = ready && idle && !req_pending;
  assign cur_mode = mode_q;

  lp_idle_timers #(.CNT_W(CNT_W)) u_timers (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .thr     (idle_thr),
    .expired (expired)
  );

  lp_mode_pick u_pick (
    .en         (mode_en),
    .auto_sel   (mode_auto),
    .expired    (expired),
    .idle       (idle),
    .req        (req_pending),
    .burst_done (burst_done),
    .go         (go),
    .pick       (pick),
    .pick_auto  (pick_auto)
  );

  lp_step_fsm #(.EXIT_W(EXIT_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .go          (go),
    .pick        (pick),
    .pick_auto   (pick_auto),
    .mobile      (mobile),
    .idle        (idle),
    .req         (req_pending),
    .en          (mode_en),
    .exit_wait   (exit_wait),
    .cke         (cke),
    .mem_clk_en  (mem_clk_en),
    .ctl_clk_en  (ctl_clk_en),
    .dll_keep    (dll_keep),
    .ref_inhibit (ref_inhibit),
    .cur_mode    (mode_q),
    .ready       (ready)
  );
endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       mem_clk_en,
  input logic       ctl_clk_en,
  input logic       dll_keep,
  input logic       ref_inhibit,
  input logic [2:0] cur_mode,
  input logic       ready
);
  assert_ctl_inside_mem_R9: assert property (@(posedge clk) disable iff (rst)
    !ctl_clk_en |-> !mem_clk_en);

  assert_mem_inside_cke_R9: assert property (@(posedge clk) disable iff (rst)
    !mem_clk_en |-> !cke);

  assert_one_step_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({cke, mem_clk_en, ctl_clk_en} ^ $past({cke, mem_clk_en, ctl_clk_en})) <= 1);

  assert_refinh_sr_R7: assert property (@(posedge clk) disable iff (rst)
    ref_inhibit |-> (!cke && cur_mode >= 3'd3));

  assert_dll_keep_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl_clk_en |-> dll_keep);

  assert_pd_clocks_R6: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == 3'd1) |-> (mem_clk_en && ctl_clk_en && !ref_inhibit));

  assert_ready_clean_R11: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cke && mem_clk_en && ctl_clk_en && !ref_inhibit && cur_mode == 3'd0));

  assert_mode_range_R12: assert property (@(posedge clk) disable iff (rst)
    cur_mode <= 3'd5);
endmodule

bind lp_seq lp_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cke         (cke),
  .mem_clk_en  (mem_clk_en),
  .ctl_clk_en  (ctl_clk_en),
  .dll_keep    (dll_keep),
  .ref_inhibit (ref_inhibit),
  .cur_mode    (cur_mode),
  .ready       (ready)
);

// File: tb/sim_lp_seq.sv
module sim_lp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int EW = 8;
  localparam int NV = 10;

  typedef struct packed {
    logic [4:0]  en;
    logic [4:0]  au;
    logic        mob;
    logic [15:0] t0, t1, t2, t3;
    logic [7:0]  ew;
    logic [2:0]  md;
    logic [7:0]  dly;
    logic        gm, gc, ri;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{5'b00001, 5'b00001, 1'b0, 16'd3, 16'd0, 16'd0, 16'd0, 8'd1, 3'd1, 8'd4, 1'b0, 1'b0, 1'b0},
    '{5'b00010, 5'b00010, 1'b0, 16'd2, 16'd0, 16'd0, 16'd0, 8'd0, 3'd2, 8'd3, 1'b0, 1'b0, 1'b0},
    '{5'b00010, 5'b00010, 1'b1, 16'd2, 16'd0, 16'd0, 16'd0, 8'd0, 3'd2, 8'd3, 1'b1, 1'b0, 1'b0},
    '{5'b00100, 5'b00100, 1'b0, 16'd0, 16'd5, 16'd0, 16'd0, 8'd3, 3'd3, 8'd6, 1'b0, 1'b0, 1'b1},
    '{5'b01000, 5'b01000, 1'b0, 16'd0, 16'd0, 16'd4, 16'd0, 8'd1, 3'd4, 8'd5, 1'b1, 1'b0, 1'b1},
    '{5'b10000, 5'b10000, 1'b0, 16'd0, 16'd0, 16'd0, 16'd3, 8'd2, 3'd5, 8'd4, 1'b1, 1'b1, 1'b1},
    '{5'b11111, 5'b11111, 1'b1, 16'd4, 16'd4, 16'd4, 16'd4, 8'd0, 3'd5, 8'd5, 1'b1, 1'b1, 1'b1},
    '{5'b00101, 5'b00101, 1'b0, 16'd2, 16'd6, 16'd0, 16'd0, 8'd0, 3'd1, 8'd3, 1'b0, 1'b0, 1'b0},
    '{5'b00101, 5'b00101, 1'b0, 16'd0, 16'd7, 16'd0, 16'd0, 8'd1, 3'd3, 8'd8, 1'b0, 1'b0, 1'b1},
    '{5'b00011, 5'b00001, 1'b1, 16'd2, 16'd0, 16'd0, 16'd0, 8'd0, 3'd1, 8'd3, 1'b0, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    mode_en = '0;
  logic [4:0]    mode_auto = '0;
  logic          mobile = 1'b0;
  logic          idle = 1'b0;
  logic          burst_done = 1'b0;
  logic          req_pending = 1'b0;
  logic [4*CW-1:0] idle_thr = '0;
  logic [EW-1:0] exit_wait = '0;
  logic          cke, mem_clk_en, ctl_clk_en, dll_keep, ref_inhibit, ready;
  logic [2:0]    cur_mode;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_seq #(.CNT_W(CW), .EXIT_W(EW)) u0 (
    .clk(clk), .rst(rst), .mode_en(mode_en), .mode_auto(mode_auto), .mobile(mobile),
    .idle(idle), .burst_done(burst_done), .req_pending(req_pending), .idle_thr(idle_thr),
    .exit_wait(exit_wait), .cke(cke), .mem_clk_en(mem_clk_en), .ctl_clk_en(ctl_clk_en),
    .dll_keep(dll_keep), .ref_inhibit(ref_inhibit), .cur_mode(cur_mode), .ready(ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cke_low(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (cke && n < 80);
  endtask

  // call at a negedge right after the exit trigger was applied
  task automatic measure_exit(input bit gm, input bit gc, input int ew, input string tag);
    int tc = 0, tm = 0, tk = 0, tr = 0;
    int ec, em, ek;
    for (int k = 1; k <= 20 + ew; k++) begin
      @(negedge clk);
      if (ctl_clk_en && tc == 0) tc = k;
      if (mem_clk_en && tm == 0) tm = k;
      if (cke && tk == 0) tk = k;
      if (ready && tr == 0) tr = k;
    end
    ec = 1;
    em = 1 + int'(gc);
    ek = 1 + int'(gc) + int'(gm);
    if (gc) chk({tag, " R11 ctl restore cycle"}, tc, ec);
    if (gm) chk({tag, " R11 mem restore cycle"}, tm, em);
    chk({tag, " R11 cke restore cycle"}, tk, ek);
    chk({tag, " R11 ready cycle"}, tr, ek + ew + 1);
    chk({tag, " R12 mode cleared"}, int'(cur_mode), 0);
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL R11 watchdog act=%0d exp=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cke", int'(cke), 1);
    chk("R1 mem_clk_en", int'(mem_clk_en), 1);
    chk("R1 ctl_clk_en", int'(ctl_clk_en), 1);
    chk("R1 dll_keep", int'(dll_keep), 0);
    chk("R1 ref_inhibit", int'(ref_inhibit), 0);
    chk("R1 cur_mode", int'(cur_mode), 0);
    chk("R1 ready", int'(ready), 1);

    // table of automatic entries (R2 R3 R4 R6 R7 R8 R9), exit by idle low (R10)
    for (int v = 0; v < NV; v++) begin
      mode_en   = VECS[v].en;
      mode_auto = VECS[v].au;
      mobile    = VECS[v].mob;
      idle_thr  = {VECS[v].t3, VECS[v].t2, VECS[v].t1, VECS[v].t0};
      exit_wait = VECS[v].ew;
      @(negedge clk);
      idle = 1'b1;
      wait_cke_low(n);
      chk($sformatf("v%0d R2 R4 entry delay", v), n, int'(VECS[v].dly));
      chk($sformatf("v%0d R12 mode at entry", v), int'(cur_mode), int'(VECS[v].md));
      repeat (4) @(negedge clk);
      chk($sformatf("v%0d R4 R12 mode", v), int'(cur_mode), int'(VECS[v].md));
      chk($sformatf("v%0d R6 R8 mem_clk_en", v), int'(mem_clk_en), int'(!VECS[v].gm));
      chk($sformatf("v%0d R8 ctl_clk_en", v), int'(ctl_clk_en), int'(!VECS[v].gc));
      chk($sformatf("v%0d R8 dll_keep", v), int'(dll_keep), int'(VECS[v].gc));
      chk($sformatf("v%0d R7 ref_inhibit", v), int'(ref_inhibit), int'(VECS[v].ri));
      idle = 1'b0;
      measure_exit(VECS[v].gm, VECS[v].gc, int'(VECS[v].ew), $sformatf("v%0d R10", v));
    end

    // R9 entry step order for mode 5
    mode_en = 5'b10000; mode_auto = 5'b10000; idle_thr = {16'd2, 48'd0}; exit_wait = '0;
    @(negedge clk);
    idle = 1'b1;
    wait_cke_low(n);
    chk("R9 step1 mem still on", int'(mem_clk_en), 1);
    @(negedge clk);
    chk("R9 step2 mem off", int'(mem_clk_en), 0);
    chk("R9 step2 ctl still on", int'(ctl_clk_en), 1);
    @(negedge clk);
    chk("R9 step3 ctl off", int'(ctl_clk_en), 0);
    idle = 1'b0;
    measure_exit(1'b1, 1'b1, 0, "R9 R10");

    // R2 pending request holds counters at zero
    mode_en = 5'b00001; mode_auto = 5'b00001; idle_thr = {48'd0, 16'd2};
    idle = 1'b1; req_pending = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 request blocks entry", int'(cke), 1);
    req_pending = 1'b0;
    wait_cke_low(n);
    chk("R2 entry after request clears", n, 3);
    idle = 1'b0;
    measure_exit(1'b0, 1'b0, 0, "R2 R10");

    // R2 one idle-low cycle restarts the counter
    idle_thr = {48'd0, 16'd5};
    @(negedge clk);
    idle = 1'b1;
    repeat (4) @(negedge clk);
    idle = 1'b0;
    @(negedge clk);
    chk("R2 not entered before threshold", int'(cke), 1);
    idle = 1'b1;
    wait_cke_low(n);
    chk("R2 counter restarted", n, 6);
    idle = 1'b0;
    measure_exit(1'b0, 1'b0, 0, "R2 R10");

    // R3 manual-only mode ignores counters; R5 waits for burst end
    mode_en = 5'b00100; mode_auto = 5'b00000; idle_thr = {16'd2, 16'd2, 16'd2, 16'd2};
    exit_wait = 8'd2;
    idle = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 R5 no entry without burst end", int'(cke), 1);
    idle = 1'b0;
    burst_done = 1'b1;
    @(negedge clk);
    burst_done = 1'b0;
    chk("R5 cke low after burst end", int'(cke), 0);
    chk("R5 R12 manual mode", int'(cur_mode), 3);
    chk("R7 ref_inhibit manual", int'(ref_inhibit), 1);
    repeat (3) @(negedge clk);
    chk("R10 manual not left on idle low", int'(cke), 0);
    mode_en = 5'b00000;
    measure_exit(1'b0, 1'b0, 2, "R10 enable cleared");

    // R5 request blocks manual entry; R10 request ends mode 5
    mode_en = 5'b10000; exit_wait = 8'd0;
    req_pending = 1'b1; burst_done = 1'b1;
    @(negedge clk);
    burst_done = 1'b0;
    chk("R5 request blocks manual entry", int'(cke), 1);
    req_pending = 1'b0; burst_done = 1'b1;
    @(negedge clk);
    burst_done = 1'b0;
    chk("R5 manual deep entry", int'(cur_mode), 5);
    repeat (3) @(negedge clk);
    chk("R8 manual deep ctl gated", int'(ctl_clk_en), 0);
    req_pending = 1'b1;
    measure_exit(1'b1, 1'b1, 0, "R10 request");
    req_pending = 1'b0; mode_en = 5'b00000;
    @(negedge clk);
    chk("R1 ready after all", int'(ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule